// File: doc/BRIEF.md
# Dual-Mask Interrupt Enable Unit

This unit sits between the interrupt sources of a processor core and the core's interrupt sequencer. It holds sixteen latched request flags and two 16-bit masks. The first is the normal enable mask. The second is a debug enable mask that marks the time-critical sources. Each cycle it names one maskable source for the core to service, or reports that none is eligible.

Software updates either mask with one of three operations: a plain load, a bitwise AND with an immediate, or a bitwise OR with an immediate. While the core runs, a source is eligible when its flag is set and its normal enable bit is set. While the core is stopped in real-time emulation, the source must also have its debug enable bit set. Sources compete by fixed priority. When the core services a source, it clears that source's flag through the acknowledge port.

Top module: `irq_dual_mask`

## Requirements
- R1: After reset, both masks read 0, no flag is pending, `irq_valid` is 0 and `irq_idx` is 0.
- R2: Mask op code 2'b01 loads the operand into that mask. The new value appears on the mask output in the cycle after the op is issued.
- R3: Mask op code 2'b10 replaces the mask with its bitwise AND with the operand, one cycle after issue.
- R4: Mask op code 2'b11 replaces the mask with its bitwise OR with the operand, one cycle after issue. Op code 2'b00 leaves the mask unchanged whatever the operand is.
- R5: Bit i of every mask, flag vector and request vector belongs to source i, and `irq_idx` reports that bit position. General sources 1 to 14 use bits 0 to 13. Bit 14 is the data-log source and bit 15 is the real-time-OS source.
- R6: With `rt_halted` low, a source is eligible when its flag and its normal enable bit are both set. The debug mask has no effect.
- R7: With `rt_halted` high, a source is eligible only when its flag, its normal enable bit and its debug enable bit are all set.
- R8: When several sources are eligible, the lowest bit index wins. Bit 0 has the highest priority and bit 15 the lowest.
- R9: A flag set while its source is masked stays pending. It is presented once a mask update enables it.
- R10: `ack_valid` with `ack_idx` = i clears flag i at the next edge. A request pulse on source i in the same cycle keeps the flag set.
- R11: When no source is eligible, `irq_valid` is 0 and `irq_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse | input | 16 | Single-cycle request pulses, one per source |
| ien_op | input | 2 | Normal mask op: 00 hold, 01 load, 10 AND, 11 OR |
| ien_opnd | input | 16 | Operand for the normal mask op |
| dien_op | input | 2 | Debug mask op, same encoding |
| dien_opnd | input | 16 | Operand for the debug mask op |
| rt_halted | input | 1 | Core is stopped in real-time emulation |
| ack_valid | input | 1 | Core acknowledges a serviced source |
| ack_idx | input | 4 | Index of the acknowledged source |
| ien_q | output | 16 | Current normal enable mask |
| dien_q | output | 16 | Current debug enable mask |
| irq_valid | output | 1 | An eligible source exists |
| irq_idx | output | 4 | Index of the winning source |

## Verification
Mask updates, flag sets and acknowledge clears each pass through exactly one register. Their effect is therefore due on the outputs one edge after the inputs are applied. `rt_halted` acts combinationally on the held register state. The bench changes inputs on the falling edge and queues the expected result for the next rising edge. It compares 1 ns after that edge, when every registered effect has settled and before any input moves again.

// File: rtl/irq_dual_mask_pkg.sv
package irq_dual_mask_pkg;
   typedef enum logic [1:0] {
      MOP_HOLD = 2'b00,
      MOP_LOAD = 2'b01,
      MOP_AND  = 2'b10,
      MOP_OR   = 2'b11
   } mask_op_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import irq_dual_mask_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] opnd,
   output logic [WIDTH-1:0] mask_q
);
   initial begin
      if (WIDTH < 1) $error("irq_mask_reg: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mask_d;

   always_comb begin
      unique case (mask_op_e'(op))
         MOP_LOAD: mask_d = opnd;
         MOP_AND:  mask_d = mask_q & opnd;
         MOP_OR:   mask_d = mask_q | opnd;
         default:  mask_d = mask_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   // R2 load lands one cycle later
   a_r2_load_next: assert property (@(posedge clk) disable iff (!rst_n)
      (op == MOP_LOAD) |=> (mask_q == $past(opnd)));
   // R4 hold keeps value
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (op == MOP_HOLD) |=> $stable(mask_q));
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
   parameter int NSRC  = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  req_pulse,
   input  logic             ack_valid,
   input  logic [IDX_W-1:0] ack_idx,
   output logic [NSRC-1:0]  flags_q
);
   initial begin
      if ((1 << IDX_W) < NSRC) $error("irq_pend_flags: IDX_W too narrow");
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_flag
      logic clr;
      assign clr = ack_valid && (ack_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            flags_q[g] <= 1'b0;
         else if (req_pulse[g]) flags_q[g] <= 1'b1;
         else if (clr)          flags_q[g] <= 1'b0;
      end

      // R10 pulse wins over clear
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         req_pulse[g] |=> flags_q[g]);
      // R10 acknowledge clears
      a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !req_pulse[g]) |=> !flags_q[g]);
      // R9 pending stays pending
      a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[g] && !clr) |=> flags_q[g]);
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NSRC  = 16,
   parameter int IDX_W = 4
) (
   input  logic [NSRC-1:0]  elig,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   initial begin
      if (NSRC < 2) $error("irq_prio_pick: NSRC must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig[i]) idx = IDX_W'(i);
      end
      any = |elig;
   end

   // R8 nothing of higher priority is eligible
   always_comb begin
      if (any) a_r8_lowest_wins: assert ((elig & ((NSRC'(1) << idx) - NSRC'(1))) == '0);
   end
endmodule

// File: rtl/irq_dual_mask.sv
module irq_dual_mask
   import irq_dual_mask_pkg::*;
#(
   parameter int NSRC = 16,
   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  req_pulse,
   input  logic [1:0]       ien_op,
   input  logic [NSRC-1:0]  ien_opnd,
   input  logic [1:0]       dien_op,
   input  logic [NSRC-1:0]  dien_opnd,
   input  logic             rt_halted,
   input  logic             ack_valid,
   input  logic [IDX_W-1:0] ack_idx,
   output logic [NSRC-1:0]  ien_q,
   output logic [NSRC-1:0]  dien_q,
   output logic             irq_valid,
   output logic [IDX_W-1:0] irq_idx
);
   initial begin
      if (NSRC < 2 || NSRC > 64) $error("irq_dual_mask: NSRC out of range");
   end

   logic [NSRC-1:0] flags_q;
   logic [NSRC-1:0] gate;
   logic [NSRC-1:0] elig;

   irq_mask_reg #(.WIDTH(NSRC)) u_ien (
      .clk(clk), .rst_n(rst_n), .op(ien_op), .opnd(ien_opnd), .mask_q(ien_q));

   irq_mask_reg #(.WIDTH(NSRC)) u_dien (
      .clk(clk), .rst_n(rst_n), .op(dien_op), .opnd(dien_opnd), .mask_q(dien_q));

   irq_pend_flags #(.NSRC(NSRC), .IDX_W(IDX_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse),
      .ack_valid(ack_valid), .ack_idx(ack_idx), .flags_q(flags_q));

   // debug mask only narrows the enable set while halted
   always_comb begin
      gate = rt_halted ? (ien_q & dien_q) : ien_q;
      elig = flags_q & gate;
   end

   irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
      .elig(elig), .any(irq_valid), .idx(irq_idx));

   // R6 winner is pending and enabled
   a_r6_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (flags_q[irq_idx] && ien_q[irq_idx]));
   // R7 halted winner is time-critical
   a_r7_halt_needs_debug: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && rt_halted) |-> dien_q[irq_idx]);
   // R11 idle index is zero
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_idx == '0));
endmodule

// File: tb/irq_dual_mask_tb.sv
module irq_dual_mask_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic        valid;
      logic [3:0]  idx;
      logic [15:0] ien;
      logic [15:0] dien;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req_pulse = '0;
   logic [1:0]  ien_op = '0;
   logic [15:0] ien_opnd = '0;
   logic [1:0]  dien_op = '0;
   logic [15:0] dien_opnd = '0;
   logic        rt_halted = 1'b0;
   logic        ack_valid = 1'b0;
   logic [3:0]  ack_idx = '0;
   logic [15:0] ien_q, dien_q;
   logic        irq_valid;
   logic [3:0]  irq_idx;

   int n_run = 0;
   int n_fail = 0;
   exp_t q[$];
   logic [15:0] m_ien = '0, m_dien = '0, m_flags = '0;

   irq_dual_mask u_dut (
      .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse),
      .ien_op(ien_op), .ien_opnd(ien_opnd),
      .dien_op(dien_op), .dien_opnd(dien_opnd),
      .rt_halted(rt_halted), .ack_valid(ack_valid), .ack_idx(ack_idx),
      .ien_q(ien_q), .dien_q(dien_q), .irq_valid(irq_valid), .irq_idx(irq_idx));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] apply(input logic [15:0] m, input logic [1:0] op,
                                         input logic [15:0] d);
      case (op)
         2'b01:   return d;
         2'b10:   return m & d;
         2'b11:   return m | d;
         default: return m;
      endcase
   endfunction

   task automatic step(input string tag, input logic [15:0] pls,
                       input logic [1:0] iop, input logic [15:0] idat,
                       input logic [1:0] dop, input logic [15:0] ddat,
                       input logic halt, input logic av, input logic [3:0] ai);
      exp_t e;
      logic [15:0] el;
      @(negedge clk);
      req_pulse = pls; ien_op = iop; ien_opnd = idat;
      dien_op = dop; dien_opnd = ddat; rt_halted = halt;
      ack_valid = av; ack_idx = ai;
      m_ien  = apply(m_ien, iop, idat);
      m_dien = apply(m_dien, dop, ddat);
      if (av) m_flags[ai] = 1'b0;
      m_flags = m_flags | pls;
      el = m_flags & m_ien & (halt ? m_dien : 16'hFFFF);
      e.valid = |el; e.idx = '0;
      for (int i = 15; i >= 0; i--) if (el[i]) e.idx = 4'(i);
      e.ien = m_ien; e.dien = m_dien; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         if (q.size() > 0) begin
            e = q.pop_front();
            #1;
            n_run++;
            if (irq_valid !== e.valid || irq_idx !== e.idx ||
                ien_q !== e.ien || dien_q !== e.dien) begin
               n_fail++;
               $display("FAIL %s: got v=%b idx=%0d ien=%h dien=%h, exp v=%b idx=%0d ien=%h dien=%h",
                        e.tag, irq_valid, irq_idx, ien_q, dien_q,
                        e.valid, e.idx, e.ien, e.dien);
            end
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_run++;
      if (ien_q !== '0 || dien_q !== '0 || irq_valid !== 1'b0 || irq_idx !== '0) begin
         n_fail++;
         $display("FAIL R1: got ien=%h dien=%h v=%b idx=%0d, exp all zero",
                  ien_q, dien_q, irq_valid, irq_idx);
      end
      rst_n = 1'b1;
      step("R1 idle after reset", '0, 2'b00, 16'hFFFF, 2'b00, 16'hFFFF, 0, 0, 0);
      step("R2 load ien",        '0, 2'b01, 16'h00F0, 2'b00, '0, 0, 0, 0);
      step("R3 and ien",         '0, 2'b10, 16'h0030, 2'b00, '0, 0, 0, 0);
      step("R4 or ien",          '0, 2'b11, 16'h8000, 2'b00, '0, 0, 0, 0);
      step("R4 hold ien",        '0, 2'b00, 16'h1234, 2'b00, 16'h5555, 0, 0, 0);
      step("R2 load dien",       '0, 2'b00, '0, 2'b01, 16'h0020, 0, 0, 0);
      step("R9 R11 masked pend", 16'h0001, 2'b00, '0, 2'b00, '0, 0, 0, 0);
      step("R6 running enable",  16'h0010, 2'b00, '0, 2'b00, '0, 0, 0, 0);
      step("R8 keep higher",     16'h0020, 2'b00, '0, 2'b00, '0, 0, 0, 0);
      step("R10 ack clears",     '0, 2'b00, '0, 2'b00, '0, 0, 1, 4'd4);
      step("R7 halted both set", '0, 2'b00, '0, 2'b00, '0, 1, 0, 0);
      step("R7 halted dbg off",  '0, 2'b00, '0, 2'b01, 16'h0000, 1, 0, 0);
      step("R6 dbg ignored",     '0, 2'b00, '0, 2'b00, '0, 0, 0, 0);
      step("R10 pulse beats ack", 16'h0020, 2'b00, '0, 2'b00, '0, 0, 1, 4'd5);
      step("R10 R11 ack last",   '0, 2'b00, '0, 2'b00, '0, 0, 1, 4'd5);
      step("R9 enable pending",  '0, 2'b11, 16'h0001, 2'b00, '0, 0, 0, 0);
      step("R5 rtos bit15",      16'h8000, 2'b00, '0, 2'b00, '0, 0, 1, 4'd0);
      step("R5 R8 datalog bit14", 16'h4000, 2'b11, 16'h4000, 2'b00, '0, 0, 0, 0);
      step("R5 int14 bit13",     16'h2000, 2'b11, 16'h2000, 2'b00, '0, 0, 0, 0);
      step("R3 and clears",      '0, 2'b10, 16'h0000, 2'b00, '0, 0, 0, 0);
      step("R4 or dien",         '0, 2'b00, '0, 2'b11, 16'h8000, 0, 0, 0);
      step("R7 halted rtos",     '0, 2'b11, 16'hFFFF, 2'b00, '0, 1, 0, 0);
      @(negedge clk);
      req_pulse = '0; ien_op = '0; dien_op = '0; ack_valid = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule